// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

A synchronous two-port word memory with a left and a right port. Each port has an active-low select, an active-low write strobe (high means read), an active-low output enable, an address and a data bus, and both ports may reach any word in the same clock cycle. Reads are registered and appear one cycle after the request. When a read and a write hit the same word in one cycle, the read returns the word's old content.

The highest address is the mailbox toward the right port. A left-port write there raises the right port's active-low interrupt, and a right-port read of that word clears it. The next-highest address is the mailbox toward the left port and works the same way with the sides swapped. Each mailbox flag is a two-state machine: MB_EMPTY moves to MB_POSTED on a post (an effective write), and MB_POSTED returns to MB_EMPTY on a take (a read by the other port) only when no post arrives in that cycle.

In master mode a collision arbiter compares the two ports. A clash is both ports selected at the same address. The arbiter's states are ARB_IDLE, ARB_L_OWNS and ARB_R_OWNS. From ARB_IDLE a clash moves to the owner's state. The owner is the port that was already selected at that address in the previous cycle, and the left port when both or neither were. From ARB_L_OWNS or ARB_R_OWNS the arbiter returns to ARB_IDLE once the clash ends. The loser's active-low busy output goes low in the clash cycle itself, and the loser's write is dropped. In slave mode the arbiter is off, both busy outputs stay high, and each port's write is blocked by its own active-low hold input.

Top module: `dpram_mailbox`

## Requirements
- R1: During and after reset both read buses are 0, and the interrupt and busy outputs are all high.
- R2: A read request (select low, write strobe high) returns the addressed word on the read bus after the next clock edge. Writes to different words on both ports in one cycle both take effect. A high output enable forces that port's read bus to 0.
- R3: A read and a write to the same word in one cycle: the read returns the word's content from before the write.
- R4: An effective left write to address 2^ADDR_W-1 drives the right interrupt low from the next edge on.
- R5: A right read of address 2^ADDR_W-1 releases the right interrupt (high) after that edge.
- R6: An effective right write to address 2^ADDR_W-2 drives the left interrupt low. A left read of that address releases it.
- R7: When a post and a take reach one mailbox in the same cycle, the interrupt stays low.
- R8: In master mode, when both ports are selected at the same address, exactly one busy output goes low in that same cycle. When both ports arrived in that cycle, the right port is the one marked busy.
- R9: A port that was selected at the clashing address in the previous cycle wins. It keeps ownership for as long as the clash continues.
- R10: The losing port's write leaves the word unchanged, and its read still returns data.
- R11: In slave mode both busy outputs stay high, and a port whose hold input is low cannot write. When both ports write the same word, the left write is kept.
- R12: A write blocked by arbitration does not post to a mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: arbiter drives busy; 0: hold inputs block writes |
| lp_cs_n | input | 1 | Left select, active low |
| lp_we_n | input | 1 | Left write strobe, low writes, high reads |
| lp_oe_n | input | 1 | Left output enable, active low |
| lp_hold_n | input | 1 | Left write block in slave mode, active low |
| lp_addr | input | ADDR_W | Left address |
| lp_wdata | input | DATA_W | Left write data |
| lp_rdata | output | DATA_W | Left read data |
| lp_busy_n | output | 1 | Left lost arbitration, active low |
| lp_irq_n | output | 1 | Left mailbox interrupt, active low |
| rp_cs_n | input | 1 | Right select, active low |
| rp_we_n | input | 1 | Right write strobe, low writes, high reads |
| rp_oe_n | input | 1 | Right output enable, active low |
| rp_hold_n | input | 1 | Right write block in slave mode, active low |
| rp_addr | input | ADDR_W | Right address |
| rp_wdata | input | DATA_W | Right write data |
| rp_rdata | output | DATA_W | Right read data |
| rp_busy_n | output | 1 | Right lost arbitration, active low |
| rp_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Every cycle, the assertions check the following. Busy never marks both ports. Busy only appears during a clash. The owning state never marks its own port busy. Busy stays quiet in slave mode. Two writes never reach one word in the same cycle. A post always leaves the flag raised, and a lone take always drops it. An interrupt only falls after an effective mailbox write. Only the bench's scenarios can show which port wins by arrival order, that ownership is held across a long clash, that blocked writes really leave the word intact, that reads are read-first, and that the mailbox words carry data like any other word.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_L_OWNS = 2'd1,
        ARB_R_OWNS = 2'd2
    } arb_state_t;

    typedef enum logic {
        MB_EMPTY  = 1'b0,
        MB_POSTED = 1'b1
    } mbox_state_t;

    typedef enum logic {
        WIN_LEFT  = 1'b0,
        WIN_RIGHT = 1'b1
    } winner_t;

endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              l_act,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_act,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              busy_l,
    output logic              busy_r
);

    arb_state_t        state_q;
    arb_state_t        state_d;
    logic              prev_l_act_q;
    logic              prev_r_act_q;
    logic [ADDR_W-1:0] prev_l_addr_q;
    logic [ADDR_W-1:0] prev_r_addr_q;
    logic              clash;
    logic              l_early;
    logic              r_early;
    winner_t           fresh_win;
    winner_t           owner;

    assign clash   = master && l_act && r_act && (l_addr == r_addr);
    assign l_early = prev_l_act_q && (prev_l_addr_q == l_addr);
    assign r_early = prev_r_act_q && (prev_r_addr_q == r_addr);

    always_comb begin
        if (r_early && !l_early) begin
            fresh_win = WIN_RIGHT;
        end else begin
            fresh_win = WIN_LEFT;
        end
    end

    // arrival history: where each port was selected one cycle ago
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_l_act_q  <= 1'b0;
            prev_r_act_q  <= 1'b0;
            prev_l_addr_q <= '0;
            prev_r_addr_q <= '0;
        end else begin
            prev_l_act_q  <= l_act;
            prev_r_act_q  <= r_act;
            prev_l_addr_q <= l_addr;
            prev_r_addr_q <= r_addr;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (clash) begin
                    state_d = (fresh_win == WIN_RIGHT) ? ARB_R_OWNS : ARB_L_OWNS;
                end
            end
            ARB_L_OWNS, ARB_R_OWNS: begin
                if (!clash) begin
                    state_d = ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ARB_L_OWNS: owner = WIN_LEFT;
            ARB_R_OWNS: owner = WIN_RIGHT;
            default:    owner = fresh_win;
        endcase
        busy_l = clash && (owner == WIN_RIGHT);
        busy_r = clash && (owner == WIN_LEFT);
    end

    // R8
    no_dual_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_l && busy_r));

    // R8
    busy_needs_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_l || busy_r) |-> (l_act && r_act && l_addr == r_addr));

    // R9
    owner_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ARB_L_OWNS) |-> !busy_l) and ((state_q == ARB_R_OWNS) |-> !busy_r));

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic take,
    output logic irq_n
);

    mbox_state_t state_q;
    mbox_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: a post outranks a take
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_EMPTY: begin
                if (post) begin
                    state_d = MB_POSTED;
                end
            end
            MB_POSTED: begin
                if (take && !post) begin
                    state_d = MB_EMPTY;
                end
            end
            default: state_d = MB_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        irq_n = (state_q != MB_POSTED);
    end

    // R4
    post_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> !irq_n);

    // R5
    take_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !post) |=> irq_n);

endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] l_rd_q;
    logic [DATA_W-1:0] r_rd_q;

    always_ff @(posedge clk) begin
        if (l_wr) begin
            mem[l_addr] <= l_wdata;
        end
        if (r_wr) begin
            mem[r_addr] <= r_wdata;
        end
    end

    // read-first: registers sample the word before this edge's writes land
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_rd_q <= '0;
            r_rd_q <= '0;
        end else begin
            if (l_rd) begin
                l_rd_q <= mem[l_addr];
            end
            if (r_rd) begin
                r_rd_q <= mem[r_addr];
            end
        end
    end

    assign l_rdata = l_rd_q;
    assign r_rdata = r_rd_q;

    // R10
    single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_wr && r_wr && l_addr == r_addr));

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              lp_cs_n,
    input  logic              lp_we_n,
    input  logic              lp_oe_n,
    input  logic              lp_hold_n,
    input  logic [ADDR_W-1:0] lp_addr,
    input  logic [DATA_W-1:0] lp_wdata,
    output logic [DATA_W-1:0] lp_rdata,
    output logic              lp_busy_n,
    output logic              lp_irq_n,
    input  logic              rp_cs_n,
    input  logic              rp_we_n,
    input  logic              rp_oe_n,
    input  logic              rp_hold_n,
    input  logic [ADDR_W-1:0] rp_addr,
    input  logic [DATA_W-1:0] rp_wdata,
    output logic [DATA_W-1:0] rp_rdata,
    output logic              rp_busy_n,
    output logic              rp_irq_n
);

    localparam logic [ADDR_W-1:0] MB_TO_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MB_TO_L = MB_TO_R - 1'b1;
    localparam int                N_MBOX  = 2;

    logic              l_act;
    logic              r_act;
    logic              l_wr_req;
    logic              r_wr_req;
    logic              l_rd_en;
    logic              r_rd_en;
    logic              l_wr_en;
    logic              r_wr_en;
    logic              l_block;
    logic              r_block;
    logic              arb_busy_l;
    logic              arb_busy_r;
    logic [DATA_W-1:0] l_rd_word;
    logic [DATA_W-1:0] r_rd_word;
    logic [N_MBOX-1:0] mb_post;
    logic [N_MBOX-1:0] mb_take;
    logic [N_MBOX-1:0] mb_irq_n;

    assign l_act    = !lp_cs_n;
    assign r_act    = !rp_cs_n;
    assign l_wr_req = l_act && !lp_we_n;
    assign r_wr_req = r_act && !rp_we_n;
    assign l_rd_en  = l_act && lp_we_n;
    assign r_rd_en  = r_act && rp_we_n;

    dpm_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .master (master_mode),
        .l_act  (l_act),
        .l_addr (lp_addr),
        .r_act  (r_act),
        .r_addr (rp_addr),
        .busy_l (arb_busy_l),
        .busy_r (arb_busy_r)
    );

    // write gating: arbiter in master mode, hold pins in slave mode
    always_comb begin
        if (master_mode) begin
            l_block = arb_busy_l;
            r_block = arb_busy_r;
        end else begin
            l_block = !lp_hold_n;
            r_block = !rp_hold_n || (l_wr_req && lp_hold_n && lp_addr == rp_addr);
        end
        l_wr_en = l_wr_req && !l_block;
        r_wr_en = r_wr_req && !r_block;
    end

    dpm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_wr    (l_wr_en),
        .l_rd    (l_rd_en),
        .l_addr  (lp_addr),
        .l_wdata (lp_wdata),
        .r_wr    (r_wr_en),
        .r_rd    (r_rd_en),
        .r_addr  (rp_addr),
        .r_wdata (rp_wdata),
        .l_rdata (l_rd_word),
        .r_rdata (r_rd_word)
    );

    // mailbox 0 signals the right port, mailbox 1 signals the left port
    assign mb_post[0] = l_wr_en && (lp_addr == MB_TO_R);
    assign mb_take[0] = r_rd_en && (rp_addr == MB_TO_R);
    assign mb_post[1] = r_wr_en && (rp_addr == MB_TO_L);
    assign mb_take[1] = l_rd_en && (lp_addr == MB_TO_L);

    for (genvar s = 0; s < N_MBOX; s++) begin : g_mbox
        dpm_mailbox u_mbox (
            .clk   (clk),
            .rst_n (rst_n),
            .post  (mb_post[s]),
            .take  (mb_take[s]),
            .irq_n (mb_irq_n[s])
        );
    end

    assign rp_irq_n  = mb_irq_n[0];
    assign lp_irq_n  = mb_irq_n[1];
    assign lp_busy_n = !arb_busy_l;
    assign rp_busy_n = !arb_busy_r;
    assign lp_rdata  = lp_oe_n ? '0 : l_rd_word;
    assign rp_rdata  = rp_oe_n ? '0 : r_rd_word;

    // R11
    slave_busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (lp_busy_n && rp_busy_n));

    // R12
    irq_r_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rp_irq_n) |-> $past(l_wr_en && lp_addr == MB_TO_R));

    // R12
    irq_l_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_irq_n) |-> $past(r_wr_en && rp_addr == MB_TO_L));

endmodule

// File: tb/test_dpram_mailbox.sv
module test_dpram_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam logic [AW-1:0] TOP  = 4'hF;
    localparam logic [AW-1:0] NEXT = 4'hE;

    localparam int K_LRD = 0, K_RRD = 1, K_LIRQ = 2, K_RIRQ = 3, K_LBUSY = 4, K_RBUSY = 5;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] val;
        string       req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          lp_cs_n = 1'b1, lp_we_n = 1'b1, lp_oe_n = 1'b0, lp_hold_n = 1'b1;
    logic [AW-1:0] lp_addr = '0;
    logic [DW-1:0] lp_wdata = '0;
    logic [DW-1:0] lp_rdata;
    logic          lp_busy_n, lp_irq_n;
    logic          rp_cs_n = 1'b1, rp_we_n = 1'b1, rp_oe_n = 1'b0, rp_hold_n = 1'b1;
    logic [AW-1:0] rp_addr = '0;
    logic [DW-1:0] rp_wdata = '0;
    logic [DW-1:0] rp_rdata;
    logic          rp_busy_n, rp_irq_n;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_mailbox (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .lp_cs_n(lp_cs_n), .lp_we_n(lp_we_n), .lp_oe_n(lp_oe_n), .lp_hold_n(lp_hold_n),
        .lp_addr(lp_addr), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
        .lp_busy_n(lp_busy_n), .lp_irq_n(lp_irq_n),
        .rp_cs_n(rp_cs_n), .rp_we_n(rp_we_n), .rp_oe_n(rp_oe_n), .rp_hold_n(rp_hold_n),
        .rp_addr(rp_addr), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata),
        .rp_busy_n(rp_busy_n), .rp_irq_n(rp_irq_n)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic logic [31:0] probe(input int kind);
        case (kind)
            K_LRD:   probe = 32'(lp_rdata);
            K_RRD:   probe = 32'(rp_rdata);
            K_LIRQ:  probe = 32'(lp_irq_n);
            K_RIRQ:  probe = 32'(rp_irq_n);
            K_LBUSY: probe = 32'(lp_busy_n);
            default: probe = 32'(rp_busy_n);
        endcase
    endfunction

    // monitor: compares queued expectations a quarter period after each edge
    initial forever begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            logic [31:0] act;
            e = sb_q.pop_front();
            act = probe(e.kind);
            checks++;
            if (act !== e.val) begin
                fails++;
                $display("FAIL %s: output %0d actual=%0h expected=%0h", e.req, e.kind, act, e.val);
            end
        end
    end

    // driver helpers
    task automatic expect_at(input int kind, input logic [31:0] val, input string req);
        exp_t e;
        e.due = cyc + 1;
        e.kind = kind;
        e.val = val;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic drive_l(input logic cs_n, input logic we_n, input logic [AW-1:0] a, input logic [DW-1:0] d);
        lp_cs_n = cs_n; lp_we_n = we_n; lp_addr = a; lp_wdata = d;
    endtask

    task automatic drive_r(input logic cs_n, input logic we_n, input logic [AW-1:0] a, input logic [DW-1:0] d);
        rp_cs_n = cs_n; rp_we_n = we_n; rp_addr = a; rp_wdata = d;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        drive_l(1'b1, 1'b1, '0, '0);
        drive_r(1'b1, 1'b1, '0, '0);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: outputs quiet during reset
        expect_at(K_LRD, 0, "R1"); expect_at(K_RRD, 0, "R1");
        expect_at(K_LIRQ, 1, "R1"); expect_at(K_RIRQ, 1, "R1");
        tick();
        tick();
        rst_n = 1'b1;
        expect_at(K_LBUSY, 1, "R1"); expect_at(K_RBUSY, 1, "R1");
        expect_at(K_LRD, 0, "R1");
        tick();

        // R2: two writes to different words, then cross reads
        drive_l(1'b0, 1'b0, 4'd3, 8'hA5);
        drive_r(1'b0, 1'b0, 4'd5, 8'h3C);
        tick();
        drive_l(1'b0, 1'b1, 4'd5, 8'h00);
        drive_r(1'b0, 1'b1, 4'd3, 8'h00);
        expect_at(K_LRD, 8'h3C, "R2"); expect_at(K_RRD, 8'hA5, "R2");
        tick();
        lp_oe_n = 1'b1;
        drive_r(1'b1, 1'b1, '0, '0);
        expect_at(K_LRD, 0, "R2");
        tick();
        lp_oe_n = 1'b0;
        idle();

        // R3 / R8: simultaneous clash, left writes, right reads old word
        drive_l(1'b0, 1'b0, 4'd3, 8'h77);
        drive_r(1'b0, 1'b1, 4'd3, 8'h00);
        expect_at(K_RRD, 8'hA5, "R3");
        expect_at(K_RBUSY, 0, "R8"); expect_at(K_LBUSY, 1, "R8");
        tick();
        drive_l(1'b1, 1'b1, '0, '0);
        drive_r(1'b0, 1'b1, 4'd3, 8'h00);
        expect_at(K_RRD, 8'h77, "R3");
        tick();
        idle();

        // R10: both write one word at once, right write is dropped
        drive_l(1'b0, 1'b0, 4'd7, 8'h11);
        drive_r(1'b0, 1'b0, 4'd7, 8'h22);
        expect_at(K_RBUSY, 0, "R10");
        tick();
        idle();
        drive_r(1'b0, 1'b1, 4'd7, 8'h00);
        expect_at(K_RRD, 8'h11, "R10");
        tick();
        idle();

        // R9: right arrives first, then holds ownership over a long clash
        drive_r(1'b0, 1'b1, 4'd9, 8'h00);
        tick();
        drive_l(1'b0, 1'b0, 4'd9, 8'h55);
        drive_r(1'b0, 1'b0, 4'd9, 8'h66);
        expect_at(K_LBUSY, 0, "R9"); expect_at(K_RBUSY, 1, "R9");
        tick();
        drive_l(1'b0, 1'b0, 4'd9, 8'h56);
        drive_r(1'b0, 1'b0, 4'd9, 8'h67);
        expect_at(K_LBUSY, 0, "R9");
        tick();
        idle();
        drive_l(1'b0, 1'b1, 4'd9, 8'h00);
        expect_at(K_LRD, 8'h67, "R9");
        expect_at(K_LBUSY, 1, "R9");
        tick();
        idle();

        // R4 / R5: mailbox toward the right port
        drive_l(1'b0, 1'b0, TOP, 8'h5A);
        expect_at(K_RIRQ, 0, "R4"); expect_at(K_LIRQ, 1, "R4");
        tick();
        drive_l(1'b1, 1'b1, '0, '0);
        drive_r(1'b0, 1'b1, TOP, 8'h00);
        expect_at(K_RIRQ, 1, "R5"); expect_at(K_RRD, 8'h5A, "R5");
        tick();
        idle();

        // R6: mailbox toward the left port
        drive_r(1'b0, 1'b0, NEXT, 8'hC3);
        expect_at(K_LIRQ, 0, "R6");
        tick();
        drive_r(1'b1, 1'b1, '0, '0);
        drive_l(1'b0, 1'b1, NEXT, 8'h00);
        expect_at(K_LIRQ, 1, "R6"); expect_at(K_LRD, 8'hC3, "R6");
        tick();
        idle();

        // R7: post and take in one cycle keep the interrupt low
        drive_l(1'b0, 1'b0, TOP, 8'h01);
        expect_at(K_RIRQ, 0, "R7");
        tick();
        drive_l(1'b0, 1'b0, TOP, 8'h02);
        drive_r(1'b0, 1'b1, TOP, 8'h00);
        expect_at(K_RIRQ, 0, "R7"); expect_at(K_RRD, 8'h01, "R7");
        tick();
        drive_l(1'b1, 1'b1, '0, '0);
        drive_r(1'b0, 1'b1, TOP, 8'h00);
        expect_at(K_RIRQ, 1, "R7"); expect_at(K_RRD, 8'h02, "R7");
        tick();
        idle();

        // R12: blocked right write to the left mailbox posts nothing
        drive_l(1'b0, 1'b1, NEXT, 8'h00);
        tick();
        drive_l(1'b0, 1'b1, NEXT, 8'h00);
        drive_r(1'b0, 1'b0, NEXT, 8'hEE);
        expect_at(K_RBUSY, 0, "R12"); expect_at(K_LIRQ, 1, "R12");
        tick();
        idle();
        drive_l(1'b0, 1'b1, NEXT, 8'h00);
        expect_at(K_LRD, 8'hC3, "R12"); expect_at(K_LIRQ, 1, "R12");
        tick();
        idle();

        // R11: slave mode, busy quiet, hold pins block writes
        master_mode = 1'b0;
        tick();
        drive_l(1'b0, 1'b0, 4'd4, 8'h81);
        drive_r(1'b0, 1'b0, 4'd4, 8'h82);
        expect_at(K_LBUSY, 1, "R11"); expect_at(K_RBUSY, 1, "R11");
        tick();
        drive_l(1'b1, 1'b1, '0, '0);
        rp_hold_n = 1'b0;
        drive_r(1'b0, 1'b0, 4'd4, 8'h90);
        tick();
        rp_hold_n = 1'b1;
        drive_r(1'b1, 1'b1, '0, '0);
        drive_l(1'b0, 1'b1, 4'd4, 8'h00);
        expect_at(K_LRD, 8'h81, "R11");
        tick();
        lp_hold_n = 1'b0;
        drive_l(1'b0, 1'b0, 4'd4, 8'hAA);
        tick();
        drive_l(1'b0, 1'b1, 4'd4, 8'h00);
        expect_at(K_LRD, 8'h81, "R11");
        tick();
        lp_hold_n = 1'b1;
        idle();
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule